// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds eight 64-bit event counters that a cache slice's monitoring logic feeds with one pulse per event per cycle. Software reaches the counters through a flat register port with byte addresses. Each counter has two registers. The count register holds the running total. The configuration register holds an 8-bit select code in its low byte, which names the event that counter follows.

No enable bit exists. A counter runs while its select code is nonzero. Writing the code back to zero stops it. A measurement usually goes like this: write zero to the count register, write a select code to start counting, write a zero code to stop, then read the total. Counters are independent of one another. Each one adds at most one per clock.

The read data is combinational from the current address and shows register contents as they stand before the next clock edge. A write takes effect at the clock edge. During the cycle in which a configuration write occurs, the newly written select code already governs that counter.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every count register and every configuration register reads as zero.
- R2: Count register n (n = 0..7) is at byte address 8·n. A read there returns that counter's full 64-bit value.
- R3: Configuration register n is at byte address 0x100 + 8·n. A write there stores all 64 bits, and a later read returns them unchanged.
- R4: When counter n has a select code c in 1..36, it adds exactly 1 in each cycle where evt_in[c-1] is high. It keeps its value in cycles where that bit is low. No other event bit affects it.
- R5: With a select code of zero, a counter keeps its value. A configuration write that sets the code to zero also blocks any increment in the same cycle, because the code being written governs that cycle.
- R6: A select code from 37 to 255 matches no event, so the counter keeps its value whatever evt_in carries.
- R7: Configuration bits 63:8 do not affect counting. Only bits 7:0 pick the event.
- R8: A write to a count register loads the written value, including zero. If that counter would also increment in the same cycle, the written value wins.
- R9: Counters wrap modulo 2^64. An increment from all ones gives zero.
- R10: Any address that is not one of the sixteen registers reads as zero, and a write to it changes no register. This includes addresses not on an 8-byte boundary and indices 8 and above.
- R11: A write changes only the register it addresses. Each counter follows only its own configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 12 | Byte address of the register being read or written |
| reg_wr | input | 1 | When high, write reg_wdata to reg_addr at the next edge |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr; zero for unmapped addresses |
| evt_in | input | 36 | Event pulses; bit k is the source for select code k+1 |

## Verification
On every cycle, the assertions check four things. A counter never moves by more than one unless it is written. A counter with a zero code and no configuration write holds still. A count or configuration write lands exactly as written. At most one register is targeted, and unmapped addresses read zero. Some behaviours depend on which event bit matches which code: the same-cycle stop, codes beyond the defined range, ignored upper configuration bits, wrap-around, and cross-counter isolation. Only the bench's reference model shows these, by comparing read data on every clock through directed scenarios and a randomized mix of writes, reads and event patterns.

// File: rtl/pcb_pkg.sv
// Package: shared constants and the register-region type for the counter bank.
// Assumes byte addressing with 64-bit registers on an 8-byte stride.
package pcb_pkg;

    localparam int unsigned WORD_BYTES      = 8;
    localparam int unsigned CNT_REGION_BASE = 'h000;
    localparam int unsigned CFG_REGION_BASE = 'h100;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_COUNT  = 2'd1,
        RGN_CONFIG = 2'd2
    } region_e;

endpackage

// File: rtl/pcb_addr_dec.sv
// Address decoder: turns a byte address into a region and a counter index,
// and produces per-counter write strobes.
// Assumes NUM_CNT >= 2. An address that is not aligned to 8 bytes, or that
// falls past the last counter of a region, maps to RGN_NONE.
module pcb_addr_dec
    import pcb_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_CNT = 8
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_en,
    output region_e                    region,
    output logic [$clog2(NUM_CNT)-1:0] idx,
    output logic [NUM_CNT-1:0]         cnt_we,
    output logic [NUM_CNT-1:0]         cfg_we
);
    localparam int IDX_W  = $clog2(NUM_CNT);
    localparam int WORD_W = ADDR_W - 3;
    localparam logic [WORD_W-1:0] CNT_WORD = WORD_W'(CNT_REGION_BASE / WORD_BYTES);
    localparam logic [WORD_W-1:0] CFG_WORD = WORD_W'(CFG_REGION_BASE / WORD_BYTES);
    localparam logic [WORD_W-1:0] SPAN     = WORD_W'(NUM_CNT);

    logic [WORD_W-1:0] word;
    logic              aligned;

    // Classify the address into a region and an index within it.
    always_comb begin
        word    = addr[ADDR_W-1:3];
        aligned = (addr[2:0] == 3'd0);
        region  = RGN_NONE;
        idx     = '0;
        if (aligned && word >= CNT_WORD && word < CNT_WORD + SPAN) begin
            region = RGN_COUNT;
            idx    = IDX_W'(word - CNT_WORD);
        end else if (aligned && word >= CFG_WORD && word < CFG_WORD + SPAN) begin
            region = RGN_CONFIG;
            idx    = IDX_W'(word - CFG_WORD);
        end
    end

    // Raise the write strobe of the one addressed register.
    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            cnt_we[i] = wr_en && (region == RGN_COUNT)  && (idx == IDX_W'(i));
            cfg_we[i] = wr_en && (region == RGN_CONFIG) && (idx == IDX_W'(i));
        end
    end

endmodule

// File: rtl/pcb_event_sel.sv
// Event selector: picks the event bit named by a select code.
// Code 0 and codes above NUM_EVENTS select nothing. Code c selects evt[c-1].
// Assumes NUM_EVENTS < 2**SEL_W.
module pcb_event_sel #(
    parameter int SEL_W      = 8,
    parameter int NUM_EVENTS = 36
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_EVENTS-1:0] evt,
    output logic                  hit
);
    // Compare the code against each defined source code.
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NUM_EVENTS; k++) begin
            if (sel == SEL_W'(k + 1)) hit = evt[k];
        end
    end

endmodule

// File: rtl/pcb_counter_slot.sv
// One counter slot: a configuration register and a count register.
// The count advances by one on each cycle in which the selected event fires.
// A configuration write governs the cycle in which it happens. A count write
// wins over an increment in the same cycle. The count wraps modulo 2**DATA_W.
module pcb_counter_slot #(
    parameter int DATA_W     = 64,
    parameter int SEL_W      = 8,
    parameter int NUM_EVENTS = 36
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_we,
    input  logic                  cfg_we,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_EVENTS-1:0] evt,
    output logic [DATA_W-1:0]     cnt_q,
    output logic [DATA_W-1:0]     cfg_q
);
    logic [SEL_W-1:0] active_sel;
    logic             hit;

    // The code being written governs this cycle; otherwise the stored code does.
    always_comb begin
        active_sel = cfg_we ? wdata[SEL_W-1:0] : cfg_q[SEL_W-1:0];
    end

    pcb_event_sel #(
        .SEL_W      (SEL_W),
        .NUM_EVENTS (NUM_EVENTS)
    ) u_sel (
        .sel (active_sel),
        .evt (evt),
        .hit (hit)
    );

    // Configuration register: stores all bits written.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= wdata;
    end

    // Count register: software load first, then the event increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= wdata;
        else if (hit)    cnt_q <= cnt_q + DATA_W'(1);
    end

    // R8: a count write lands exactly as written.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_q == $past(wdata));

    // R3: a configuration write stores the full word.
    a_r3_cfg_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_q == $past(wdata));

    // R4: without a write the count moves by at most one.
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + DATA_W'(1)));

    // R5: a stopped counter with no write holds still.
    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !cfg_we && cfg_q[SEL_W-1:0] == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/pcb_read_mux.sv
// Read mux: returns the register named by region and index, or zero when
// the address decodes to no register.
module pcb_read_mux
    import pcb_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int NUM_CNT = 8
) (
    input  region_e                         region,
    input  logic [$clog2(NUM_CNT)-1:0]      idx,
    input  logic [NUM_CNT-1:0][DATA_W-1:0]  cnt_bank,
    input  logic [NUM_CNT-1:0][DATA_W-1:0]  cfg_bank,
    output logic [DATA_W-1:0]               rdata
);
    // Pick the addressed register for the read data.
    always_comb begin
        unique case (region)
            RGN_COUNT:  rdata = cnt_bank[idx];
            RGN_CONFIG: rdata = cfg_bank[idx];
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/perf_counter_bank.sv
// Top of the performance event counter bank: NUM_CNT counter slots behind a
// byte-addressed register port. Count registers start at the count region
// base and configuration registers at the configuration region base, each
// on an 8-byte stride. Read data is combinational from reg_addr.
// Assumes a single clock and synchronous active-low reset.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CNT    = 8,
    parameter int DATA_W     = 64,
    parameter int SEL_W      = 8,
    parameter int NUM_EVENTS = 36,
    parameter int ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_EVENTS-1:0] evt_in
);
    localparam int IDX_W = $clog2(NUM_CNT);

    region_e                        region;
    logic [IDX_W-1:0]               idx;
    logic [NUM_CNT-1:0]             cnt_we;
    logic [NUM_CNT-1:0]             cfg_we;
    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_bank;
    logic [NUM_CNT-1:0][DATA_W-1:0] cfg_bank;

    pcb_addr_dec #(
        .ADDR_W  (ADDR_W),
        .NUM_CNT (NUM_CNT)
    ) u_dec (
        .addr   (reg_addr),
        .wr_en  (reg_wr),
        .region (region),
        .idx    (idx),
        .cnt_we (cnt_we),
        .cfg_we (cfg_we)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
        pcb_counter_slot #(
            .DATA_W     (DATA_W),
            .SEL_W      (SEL_W),
            .NUM_EVENTS (NUM_EVENTS)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_we (cnt_we[g]),
            .cfg_we (cfg_we[g]),
            .wdata  (reg_wdata),
            .evt    (evt_in),
            .cnt_q  (cnt_bank[g]),
            .cfg_q  (cfg_bank[g])
        );
    end

    pcb_read_mux #(
        .DATA_W  (DATA_W),
        .NUM_CNT (NUM_CNT)
    ) u_rmux (
        .region   (region),
        .idx      (idx),
        .cnt_bank (cnt_bank),
        .cfg_bank (cfg_bank),
        .rdata    (reg_rdata)
    );

    // R11: a write reaches at most one register.
    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_we, cfg_we}));

    // R10: an unmapped address reads zero.
    a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_NONE) |-> reg_rdata == '0);

endmodule

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
// Bench: drives the register port and event vector, and keeps a behavioural
// model of all sixteen registers. Each clock it compares the read data for
// the driven address with the model.
module perf_counter_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [35:0] evt_in = '0;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_cnt [8];
    logic [63:0] m_cfg [8];

    always #10 clk = ~clk;

    perf_counter_bank u_perf_counter_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in)
    );

    function automatic logic [63:0] model_read(input logic [11:0] a);
        for (int i = 0; i < 8; i++) begin
            if (a == 12'(i * 8))          return m_cnt[i];
            if (a == 12'('h100 + i * 8))  return m_cfg[i];
        end
        return 64'd0;
    endfunction

    // One clock: drive, compare the pre-edge read, advance the model.
    task automatic step(input logic [11:0] a, input logic we, input logic [63:0] d,
                        input logic [35:0] ev, input string tag);
        logic [63:0] exp_rd;
        logic [63:0] n_cnt [8];
        logic [63:0] n_cfg [8];
        @(negedge clk);
        reg_addr = a; reg_wr = we; reg_wdata = d; evt_in = ev;
        #2;
        exp_rd = model_read(a);
        checks++;
        if (reg_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp_rd);
        end
        for (int i = 0; i < 8; i++) begin
            logic       wc, wf, hit;
            logic [7:0] code;
            wc = we && (a == 12'(i * 8));
            wf = we && (a == 12'('h100 + i * 8));
            code = wf ? d[7:0] : m_cfg[i][7:0];
            hit = (code >= 8'd1 && code <= 8'd36) ? ev[code - 8'd1] : 1'b0;
            n_cnt[i] = wc ? d : (hit ? m_cnt[i] + 64'd1 : m_cnt[i]);
            n_cfg[i] = wf ? d : m_cfg[i];
        end
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            m_cnt[i] = n_cnt[i];
            m_cfg[i] = n_cfg[i];
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [35:0] ev, input string tag);
        step(a, 1'b0, 64'd0, ev, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [35:0] ev,
                      input string tag);
        step(a, 1'b1, d, ev, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) rd(12'(i * 8), 36'd0, tag);
        for (int i = 0; i < 8; i++) rd(12'('h100 + i * 8), 36'd0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_cnt[i] = '0; m_cfg[i] = '0; end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: everything zero after reset
        read_all("R1");

        // R3 and R7: config 2 with upper bits set, code 5
        wr(12'h110, 64'hDEAD_BEEF_0000_0105, 36'd0, "R3");
        rd(12'h110, 36'd0, "R3");
        // R7: only evt_in[4] counts for counter 2
        rd(12'h010, 36'h0_0000_0010, "R7");
        rd(12'h010, 36'hF_FFFF_FFEF, "R7");
        rd(12'h010, 36'h0_0000_0010, "R7");

        // R4: counter 0 with code 1, varied pulse patterns
        wr(12'h000, 64'd0, 36'd0, "R8");
        wr(12'h100, 64'h01, 36'h0_0000_0001, "R4");
        for (int k = 0; k < 12; k++) rd(12'h000, 36'((k % 3 == 0) ? 1 : 2), "R4");
        // R2: count reads by address
        rd(12'h000, 36'd0, "R2");

        // R5: stop write in the same cycle as the event, then idle
        wr(12'h100, 64'h00, 36'h0_0000_0001, "R5");
        for (int k = 0; k < 4; k++) rd(12'h000, 36'hF_FFFF_FFFF, "R5");

        // R6: out-of-range code on counter 1
        wr(12'h108, 64'h30, 36'hF_FFFF_FFFF, "R6");
        for (int k = 0; k < 4; k++) rd(12'h008, 36'hF_FFFF_FFFF, "R6");
        wr(12'h108, 64'hFF, 36'hF_FFFF_FFFF, "R6");
        rd(12'h008, 36'hF_FFFF_FFFF, "R6");
        wr(12'h108, 64'h25, 36'hF_FFFF_FFFF, "R6");
        rd(12'h008, 36'hF_FFFF_FFFF, "R6");

        // R8: load wins over a same-cycle increment on counter 3
        wr(12'h118, 64'h24, 36'h8_0000_0000, "R8");
        rd(12'h018, 36'h8_0000_0000, "R8");
        wr(12'h018, 64'h1234_5678_9ABC_DEF0, 36'h8_0000_0000, "R8");
        rd(12'h018, 36'd0, "R8");

        // R9: wrap on counter 4 with code 36
        wr(12'h120, 64'h24, 36'd0, "R9");
        wr(12'h020, 64'hFFFF_FFFF_FFFF_FFFE, 36'd0, "R9");
        rd(12'h020, 36'h8_0000_0000, "R9");
        rd(12'h020, 36'h8_0000_0000, "R9");
        rd(12'h020, 36'd0, "R9");

        // R10: unmapped and misaligned writes and reads
        wr(12'h0C4, 64'hAAAA_AAAA_AAAA_AAAA, 36'd0, "R10");
        wr(12'h140, 64'h0000_0000_0000_0001, 36'd0, "R10");
        wr(12'h104, 64'h0000_0000_0000_0001, 36'd0, "R10");
        wr(12'h800, 64'h5555_5555_5555_5555, 36'd0, "R10");
        rd(12'h0C4, 36'd0, "R10");
        rd(12'h040, 36'd0, "R10");
        rd(12'h103, 36'd0, "R10");
        rd(12'hFF8, 36'd0, "R10");
        read_all("R10");

        // R11: randomized mix across all counters
        for (int k = 0; k < 600; k++) begin
            logic [11:0] a;
            logic [63:0] d;
            int unsigned pick;
            pick = $urandom % 4;
            case (pick)
                0: a = 12'(($urandom % 8) * 8);
                1: a = 12'('h100 + ($urandom % 8) * 8);
                2: a = 12'($urandom);
                default: a = 12'(($urandom % 8) * 8);
            endcase
            d = {32'($urandom), 32'($urandom)};
            if ($urandom % 2 == 0) d[7:0] = 8'($urandom % 41);
            step(a, ($urandom % 3) == 0, d, 36'({$urandom, $urandom}), "R11");
        end
        read_all("R11");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule